// File: doc/BRIEF.md
# Dual-Port Block RAM with Selectable Write-Cycle Output

This block is an 18-kilobit true dual-port synchronous RAM driven by one clock. The storage is a plain register array of 9-bit units: 8 data bits and 1 parity bit each. At the default size of 2048 units, that gives 18432 bits. Each of the two ports has its own enable, write enable, address and data.

Each port has its own width, set by a lane count: 1, 2, 4 or 8 nine-bit lanes, which gives x9, x18, x36 or x72. At every width the port can still address the whole array.

Each port fixes, by parameter, what its registered read output shows during a write cycle:

- **Normal:** the old output is held.
- **Write-through:** the written word is shown.
- **Read-before-write:** the word the address held before the write is shown.

Read-before-write is honoured only at x9, x18 and x36. At x72 it quietly acts as normal.

When parity checking is enabled, every read compares each lane's stored ninth bit with the recomputed even parity of its eight data bits and raises a flag on a mismatch. When both ports write overlapping units in one cycle, port A's data is kept and a collision pulse is raised.

Top module: `tdp_bram`

## Requirements
- R1: The array holds UNITS 9-bit units, 2048 by default. A port with L lanes (L is 1, 2, 4 or 8) has a word of 9*L bits. Lane l of the word occupies bits 9l+8..9l and maps to unit addr*L+l, so every unit is reachable at every width.
- R2: With en=1 and we=0 on a port, the addressed word appears on that port's rdata after the next rising clock edge (one cycle of latency).
- R3: In normal mode (mode code 0), a write cycle stores the word and leaves rdata unchanged.
- R4: In write-through mode (mode code 1), rdata equals the written word after the write edge.
- R5: In read-before-write mode (mode code 2), rdata after the write edge equals the content the addressed units held before the write.
- R6: Read-before-write is honoured only at 1, 2 or 4 lanes. A port of 8 lanes that requests it behaves exactly like normal mode.
- R7: With en=0, a port neither writes nor changes its rdata or perr, whatever we, addr and wdata carry.
- R8: Both ports operate in the same cycle. A port that reads units the other port writes in that cycle gets their old content.
- R9: When the two ports write overlapping units in the same cycle, port A's lane data is stored, and coll is 1 for exactly the following cycle. Otherwise coll is 0.
- R10: Bit 8 of each lane is stored as supplied. With PARITY_EN=1, perr is updated together with rdata and is 1 when any lane's bit 8 differs from the XOR of its bits 7..0. With PARITY_EN=0, perr stays 0.
- R11: While rst_n is low, rdata of both ports, both perr outputs and coll are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | log2(UNITS/A_LANES) | Port A word address |
| a_wdata | input | 9*A_LANES | Port A write word |
| a_rdata | output | 9*A_LANES | Port A registered read word |
| a_perr | output | 1 | Port A parity mismatch flag |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | log2(UNITS/B_LANES) | Port B word address |
| b_wdata | input | 9*B_LANES | Port B write word |
| b_rdata | output | 9*B_LANES | Port B registered read word |
| b_perr | output | 1 | Port B parity mismatch flag |
| coll | output | 1 | Same-cycle overlapping write pulse |

## Verification
The bench drives two small instances and fills and reads back every address at several widths. This catches a lane-to-unit mapping error, which would show up as scrambled or shifted words when data written through a narrow port is read through a wide one.

The bench exercises each of the three write-cycle behaviours, plus the x72 fallback. A design that mixed up the modes would show the new word where the old one belongs, or would move an output that must hold.

The bench also forces overlapping and disjoint simultaneous writes and a read of units the other port is writing. A wrong priority would keep port B's data. A loose overlap test would raise coll spuriously. Read-after-write forwarding would return new data where old data is required.

Finally, the bench stores deliberately wrong parity bits. A checker that recomputed parity over the wrong bits, or ignored PARITY_EN, would raise or miss perr.

// File: rtl/tdp_bram_pkg.sv
package tdp_bram_pkg;

    typedef enum logic [1:0] {
        WM_NORMAL = 2'd0,
        WM_THRU   = 2'd1,
        WM_OLD    = 2'd2
    } wmode_e;

    localparam int UNIT_W = 9;

    // Old-content output is only honoured at 1, 2 or 4 lanes (R6)
    function automatic wmode_e eff_mode(input wmode_e m, input int lanes);
        if (m == WM_OLD && !(lanes == 1 || lanes == 2 || lanes == 4))
            return WM_NORMAL;
        return m;
    endfunction

    function automatic logic lane_bad(input logic [UNIT_W-1:0] u);
        return (^u[7:0]) != u[8];
    endfunction

endpackage

// File: rtl/tdp_bram_array.sv
module tdp_bram_array
    import tdp_bram_pkg::*;
#(
    parameter int UNITS   = 2048,
    parameter int A_LANES = 1,
    parameter int B_LANES = 4,
    localparam int UW   = $clog2(UNITS),
    localparam int A_AW = $clog2(UNITS / A_LANES),
    localparam int B_AW = $clog2(UNITS / B_LANES),
    localparam int A_W  = UNIT_W * A_LANES,
    localparam int B_W  = UNIT_W * B_LANES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            a_wr,
    input  logic [A_AW-1:0] a_addr,
    input  logic [A_W-1:0]  a_wdata,
    output logic [A_W-1:0]  a_old,
    input  logic            b_wr,
    input  logic [B_AW-1:0] b_addr,
    input  logic [B_W-1:0]  b_wdata,
    output logic [B_W-1:0]  b_old,
    output logic            coll
);
    localparam int A_SH = $clog2(A_LANES);
    localparam int B_SH = $clog2(B_LANES);

    logic [UNIT_W-1:0] mem [UNITS];
    logic [UW-1:0]     a_base, b_base;
    logic              overlap;

    assign a_base = UW'(a_addr) << A_SH;
    assign b_base = UW'(b_addr) << B_SH;

    // combinational read of the pre-write content
    for (genvar l = 0; l < A_LANES; l++) begin : g_rd_a
        assign a_old[UNIT_W*l +: UNIT_W] = mem[a_base + UW'(l)];
    end
    for (genvar l = 0; l < B_LANES; l++) begin : g_rd_b
        assign b_old[UNIT_W*l +: UNIT_W] = mem[b_base + UW'(l)];
    end

    // port B first, port A last so A wins on shared units
    always_ff @(posedge clk) begin
        if (b_wr) begin
            for (int l = 0; l < B_LANES; l++)
                mem[b_base + UW'(l)] <= b_wdata[UNIT_W*l +: UNIT_W];
        end
        if (a_wr) begin
            for (int l = 0; l < A_LANES; l++)
                mem[a_base + UW'(l)] <= a_wdata[UNIT_W*l +: UNIT_W];
        end
    end

    // unit ranges [base, base+lanes) intersect
    assign overlap = ({1'b0, a_base} < ({1'b0, b_base} + (UW+1)'(B_LANES))) &&
                     ({1'b0, b_base} < ({1'b0, a_base} + (UW+1)'(A_LANES)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) coll <= 1'b0;
        else        coll <= a_wr && b_wr && overlap;
    end

endmodule

// File: rtl/tdp_bram_port.sv
module tdp_bram_port
    import tdp_bram_pkg::*;
#(
    parameter int     LANES     = 1,
    parameter wmode_e MODE      = WM_NORMAL,
    parameter bit     PARITY_EN = 1'b1,
    localparam int W = UNIT_W * LANES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] old,
    output logic [W-1:0] dout,
    output logic         perr
);
    localparam wmode_e EFF = eff_mode(MODE, LANES);

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_READ,
        OP_WRITE
    } op_e;

    op_e          op;
    logic         upd;
    logic [W-1:0] nxt;
    logic [LANES-1:0] lane_err;
    logic         nxt_perr;

    always_comb begin
        if (!en)     op = OP_IDLE;
        else if (we) op = OP_WRITE;
        else         op = OP_READ;
    end

    always_comb begin
        upd = 1'b0;
        nxt = dout;
        unique case (op)
            OP_IDLE: begin
                upd = 1'b0;
            end
            OP_READ: begin
                upd = 1'b1;
                nxt = old;
            end
            OP_WRITE: begin
                case (EFF)
                    WM_THRU: begin
                        upd = 1'b1;
                        nxt = wdata;
                    end
                    WM_OLD: begin
                        upd = 1'b1;
                        nxt = old;
                    end
                    default: upd = 1'b0;
                endcase
            end
            default: upd = 1'b0;
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_par
        assign lane_err[l] = lane_bad(nxt[UNIT_W*l +: UNIT_W]);
    end
    assign nxt_perr = PARITY_EN && (|lane_err);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
            perr <= 1'b0;
        end else if (upd) begin
            dout <= nxt;
            perr <= nxt_perr;
        end
    end

endmodule

// File: rtl/tdp_bram.sv
module tdp_bram
    import tdp_bram_pkg::*;
#(
    parameter int     UNITS     = 2048,
    parameter int     A_LANES   = 1,
    parameter int     B_LANES   = 4,
    parameter wmode_e A_MODE    = WM_THRU,
    parameter wmode_e B_MODE    = WM_OLD,
    parameter bit     PARITY_EN = 1'b1,
    localparam int A_AW = $clog2(UNITS / A_LANES),
    localparam int B_AW = $clog2(UNITS / B_LANES),
    localparam int A_W  = UNIT_W * A_LANES,
    localparam int B_W  = UNIT_W * B_LANES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            a_en,
    input  logic            a_we,
    input  logic [A_AW-1:0] a_addr,
    input  logic [A_W-1:0]  a_wdata,
    output logic [A_W-1:0]  a_rdata,
    output logic            a_perr,
    input  logic            b_en,
    input  logic            b_we,
    input  logic [B_AW-1:0] b_addr,
    input  logic [B_W-1:0]  b_wdata,
    output logic [B_W-1:0]  b_rdata,
    output logic            b_perr,
    output logic            coll
);
    localparam int EFF_A = int'(eff_mode(A_MODE, A_LANES));
    localparam int EFF_B = int'(eff_mode(B_MODE, B_LANES));

    logic [A_W-1:0] a_old;
    logic [B_W-1:0] b_old;

    tdp_bram_array #(
        .UNITS  (UNITS),
        .A_LANES(A_LANES),
        .B_LANES(B_LANES)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_wr   (a_en && a_we),
        .a_addr (a_addr),
        .a_wdata(a_wdata),
        .a_old  (a_old),
        .b_wr   (b_en && b_we),
        .b_addr (b_addr),
        .b_wdata(b_wdata),
        .b_old  (b_old),
        .coll   (coll)
    );

    tdp_bram_port #(
        .LANES    (A_LANES),
        .MODE     (A_MODE),
        .PARITY_EN(PARITY_EN)
    ) u_port_a (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (a_en),
        .we   (a_we),
        .wdata(a_wdata),
        .old  (a_old),
        .dout (a_rdata),
        .perr (a_perr)
    );

    tdp_bram_port #(
        .LANES    (B_LANES),
        .MODE     (B_MODE),
        .PARITY_EN(PARITY_EN)
    ) u_port_b (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (b_en),
        .we   (b_we),
        .wdata(b_wdata),
        .old  (b_old),
        .dout (b_rdata),
        .perr (b_perr)
    );

endmodule

// File: rtl/tdp_bram_chk.sv
module tdp_bram_chk #(
    parameter int A_W   = 9,
    parameter int B_W   = 36,
    parameter int EFF_A = 0,
    parameter int EFF_B = 0
) (
    input logic           clk,
    input logic           rst_n,
    input logic           a_en,
    input logic           a_we,
    input logic [A_W-1:0] a_wdata,
    input logic [A_W-1:0] a_rdata,
    input logic [A_W-1:0] a_old,
    input logic           a_perr,
    input logic           b_en,
    input logic           b_we,
    input logic [B_W-1:0] b_wdata,
    input logic [B_W-1:0] b_rdata,
    input logic [B_W-1:0] b_old,
    input logic           b_perr,
    input logic           coll
);
    // R3, R6: normal (or fallback) output holds on a write
    p_normal_hold_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (EFF_A == 0 && a_en && a_we) |=> $stable(a_rdata));
    p_normal_hold_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (EFF_B == 0 && b_en && b_we) |=> $stable(b_rdata));

    // R4: write-through shows the written word
    p_thru_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (EFF_A == 1 && a_en && a_we) |=> a_rdata == $past(a_wdata));
    p_thru_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (EFF_B == 1 && b_en && b_we) |=> b_rdata == $past(b_wdata));

    // R5: read-before-write shows the array content seen before the edge
    p_old_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (EFF_A == 2 && a_en && a_we) |=> a_rdata == $past(a_old));
    p_old_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (EFF_B == 2 && b_en && b_we) |=> b_rdata == $past(b_old));

    // R2: a read returns the array word seen at the edge
    p_read_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && !a_we) |=> a_rdata == $past(a_old));
    p_read_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && !b_we) |=> b_rdata == $past(b_old));

    // R7: a disabled port holds its outputs
    p_idle_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |=> ($stable(a_rdata) && $stable(a_perr)));
    p_idle_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> ($stable(b_rdata) && $stable(b_perr)));

    // R9: a collision pulse only follows a cycle with two writes
    p_coll_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        coll |-> $past(a_en && a_we && b_en && b_we));
    p_coll_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_en && a_we && b_en && b_we) |=> !coll);

endmodule

bind tdp_bram tdp_bram_chk #(
    .A_W  (A_W),
    .B_W  (B_W),
    .EFF_A(EFF_A),
    .EFF_B(EFF_B)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_en   (a_en),
    .a_we   (a_we),
    .a_wdata(a_wdata),
    .a_rdata(a_rdata),
    .a_old  (a_old),
    .a_perr (a_perr),
    .b_en   (b_en),
    .b_we   (b_we),
    .b_wdata(b_wdata),
    .b_rdata(b_rdata),
    .b_old  (b_old),
    .b_perr (b_perr),
    .coll   (coll)
);

// File: tb/tdp_bram_tb.sv
`timescale 1ns/1ps
module tdp_bram_tb;
    import tdp_bram_pkg::*;

    localparam int UN = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // instance 1: A x9 write-through, B x36 read-before-write, parity on
    logic        a1_en = 0, a1_we = 0; logic [5:0] a1_addr = '0; logic [8:0]  a1_wdata = '0;
    logic [8:0]  a1_rdata; logic a1_perr;
    logic        b1_en = 0, b1_we = 0; logic [3:0] b1_addr = '0; logic [35:0] b1_wdata = '0;
    logic [35:0] b1_rdata; logic b1_perr; logic coll1;

    // instance 2: A x18 normal, B x72 requesting read-before-write, parity off
    logic        a2_en = 0, a2_we = 0; logic [4:0] a2_addr = '0; logic [17:0] a2_wdata = '0;
    logic [17:0] a2_rdata; logic a2_perr;
    logic        b2_en = 0, b2_we = 0; logic [2:0] b2_addr = '0; logic [71:0] b2_wdata = '0;
    logic [71:0] b2_rdata; logic b2_perr; logic coll2;

    tdp_bram #(.UNITS(UN), .A_LANES(1), .B_LANES(4), .A_MODE(WM_THRU),
               .B_MODE(WM_OLD), .PARITY_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_en(a1_en), .a_we(a1_we), .a_addr(a1_addr), .a_wdata(a1_wdata),
        .a_rdata(a1_rdata), .a_perr(a1_perr),
        .b_en(b1_en), .b_we(b1_we), .b_addr(b1_addr), .b_wdata(b1_wdata),
        .b_rdata(b1_rdata), .b_perr(b1_perr), .coll(coll1));

    tdp_bram #(.UNITS(UN), .A_LANES(2), .B_LANES(8), .A_MODE(WM_NORMAL),
               .B_MODE(WM_OLD), .PARITY_EN(1'b0)) u_dut_fb (
        .clk(clk), .rst_n(rst_n),
        .a_en(a2_en), .a_we(a2_we), .a_addr(a2_addr), .a_wdata(a2_wdata),
        .a_rdata(a2_rdata), .a_perr(a2_perr),
        .b_en(b2_en), .b_we(b2_we), .b_addr(b2_addr), .b_wdata(b2_wdata),
        .b_rdata(b2_rdata), .b_perr(b2_perr), .coll(coll2));

    logic [8:0] m1 [UN];
    logic [8:0] m2 [UN];

    function automatic logic [8:0] gu(input int i, input int s);
        logic [7:0] d;
        d = 8'(i * 37 + s * 11 + 5);
        return {^d, d};
    endfunction

    function automatic logic [35:0] pk1(input int j);
        logic [35:0] w;
        for (int l = 0; l < 4; l++) w[9*l +: 9] = m1[4*j + l];
        return w;
    endfunction

    function automatic logic [17:0] pa2(input int j);
        return {m2[2*j + 1], m2[2*j]};
    endfunction

    function automatic logic [71:0] pb2(input int j);
        logic [71:0] w;
        for (int l = 0; l < 8; l++) w[9*l +: 9] = m2[8*j + l];
        return w;
    endfunction

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [71:0] prev;
        logic [35:0] w36;
        logic [8:0]  x9;
        logic [71:0] w72;

        // R11: reset state
        repeat (3) tick();
        chk("R11 a1_rdata", 72'(a1_rdata), 72'h0);
        chk("R11 b1_rdata", 72'(b1_rdata), 72'h0);
        chk("R11 a2/b2 rdata", 72'(a2_rdata) | b2_rdata, 72'h0);
        chk("R11 perr/coll", 72'({a1_perr, b1_perr, a2_perr, b2_perr, coll1, coll2}), 72'h0);
        rst_n = 1'b1;
        tick();

        // R4: write-through fill of every unit through the x9 port
        for (int i = 0; i < UN; i++) begin
            a1_en = 1; a1_we = 1; a1_addr = 6'(i); a1_wdata = gu(i, 0);
            tick();
            m1[i] = gu(i, 0);
            chk("R4 write-through", 72'(a1_rdata), 72'(gu(i, 0)));
        end
        a1_en = 0; a1_we = 0;

        // R1, R2: read the whole array through the x36 port
        for (int j = 0; j < UN / 4; j++) begin
            b1_en = 1; b1_we = 0; b1_addr = 4'(j);
            tick();
            chk("R1 R2 wide read", 72'(b1_rdata), 72'(pk1(j)));
            chk("R10 good parity", 72'(b1_perr), 72'h0);
        end
        b1_en = 0;

        // R5: read-before-write on the x36 port
        for (int j = 0; j < UN / 4; j++) begin
            for (int l = 0; l < 4; l++) w36[9*l +: 9] = gu(4*j + l, 1);
            prev = 72'(pk1(j));
            b1_en = 1; b1_we = 1; b1_addr = 4'(j); b1_wdata = w36;
            tick();
            chk("R5 old content", 72'(b1_rdata), prev);
            for (int l = 0; l < 4; l++) m1[4*j + l] = w36[9*l +: 9];
        end
        b1_en = 0; b1_we = 0;

        // R1, R2: narrow readback of what the wide port wrote
        for (int i = 0; i < UN; i++) begin
            a1_en = 1; a1_we = 0; a1_addr = 6'(i);
            tick();
            chk("R1 R2 narrow read", 72'(a1_rdata), 72'(m1[i]));
        end
        a1_en = 0;

        // R10: a stored bad parity bit is flagged on read
        x9 = gu(5, 3); x9[8] = ~x9[8];
        a1_en = 1; a1_we = 1; a1_addr = 6'd5; a1_wdata = x9;
        tick();
        m1[5] = x9;
        chk("R10 perr on write-through", 72'(a1_perr), 72'h1);
        a1_we = 0; a1_addr = 6'd6;
        tick();
        chk("R10 perr clear on good read", 72'(a1_perr), 72'h0);
        a1_addr = 6'd5;
        tick();
        chk("R10 perr on bad read", 72'(a1_perr), 72'h1);
        chk("R10 bit8 stored as given", 72'(a1_rdata), 72'(x9));
        a1_en = 0;
        b1_en = 1; b1_we = 0; b1_addr = 4'd1;
        tick();
        chk("R10 perr on wide read", 72'(b1_perr), 72'h1);
        b1_en = 0;

        // R7: disabled port ignores a write and holds its outputs
        a1_en = 0; a1_we = 1; a1_addr = 6'd7; a1_wdata = 9'h1AA;
        tick(); tick();
        chk("R7 rdata held", 72'(a1_rdata), 72'(x9));
        chk("R7 perr held", 72'(a1_perr), 72'h1);
        a1_en = 1; a1_we = 0;
        tick();
        chk("R7 no write stored", 72'(a1_rdata), 72'(m1[7]));
        a1_en = 0;

        // R9: overlapping simultaneous writes; A wins on unit 9
        for (int l = 0; l < 4; l++) w36[9*l +: 9] = gu(8 + l, 7);
        a1_en = 1; a1_we = 1; a1_addr = 6'd9; a1_wdata = gu(9, 9);
        b1_en = 1; b1_we = 1; b1_addr = 4'd2; b1_wdata = w36;
        tick();
        chk("R9 coll raised", 72'(coll1), 72'h1);
        for (int l = 0; l < 4; l++) m1[8 + l] = w36[9*l +: 9];
        m1[9] = gu(9, 9);
        a1_en = 0; a1_we = 0; b1_en = 1; b1_we = 0; b1_addr = 4'd2;
        tick();
        chk("R9 coll one cycle", 72'(coll1), 72'h0);
        chk("R9 port A wins", 72'(b1_rdata), 72'(pk1(2)));

        // R9: disjoint simultaneous writes, no collision
        for (int l = 0; l < 4; l++) w36[9*l +: 9] = gu(12 + l, 4);
        a1_en = 1; a1_we = 1; a1_addr = 6'd0; a1_wdata = gu(0, 4);
        b1_en = 1; b1_we = 1; b1_addr = 4'd3; b1_wdata = w36;
        tick();
        chk("R9 no coll when disjoint", 72'(coll1), 72'h0);
        for (int l = 0; l < 4; l++) m1[12 + l] = w36[9*l +: 9];
        m1[0] = gu(0, 4);
        a1_we = 0; b1_we = 0; a1_addr = 6'd0; b1_addr = 4'd3;
        tick();
        chk("R8 both ports read A", 72'(a1_rdata), 72'(m1[0]));
        chk("R8 both ports read B", 72'(b1_rdata), 72'(pk1(3)));

        // R8: read of units the other port writes gives old content
        prev = 72'(pk1(5));
        a1_en = 1; a1_we = 1; a1_addr = 6'd21; a1_wdata = gu(21, 6);
        b1_en = 1; b1_we = 0; b1_addr = 4'd5;
        tick();
        chk("R8 cross-port old read", 72'(b1_rdata), prev);
        m1[21] = gu(21, 6);
        a1_en = 0; a1_we = 0;
        tick();
        chk("R8 new content later", 72'(b1_rdata), 72'(pk1(5)));
        b1_en = 0;

        // R3: normal mode holds rdata through writes (x18 port)
        prev = 72'(a2_rdata);
        for (int j = 0; j < UN / 2; j++) begin
            a2_en = 1; a2_we = 1; a2_addr = 5'(j);
            a2_wdata = {gu(2*j + 1, 2), gu(2*j, 2)};
            tick();
            m2[2*j] = gu(2*j, 2); m2[2*j + 1] = gu(2*j + 1, 2);
            chk("R3 normal holds", 72'(a2_rdata), prev);
        end
        for (int j = 0; j < UN / 2; j++) begin
            a2_en = 1; a2_we = 0; a2_addr = 5'(j);
            tick();
            chk("R2 x18 read", 72'(a2_rdata), 72'(pa2(j)));
        end
        a2_en = 0;

        // R6: x72 port requesting old-content output acts as normal
        b2_en = 1; b2_we = 0; b2_addr = 3'd7;
        tick();
        prev = b2_rdata;
        for (int j = 0; j < UN / 8; j++) begin
            for (int l = 0; l < 8; l++) w72[9*l +: 9] = gu(8*j + l, 5);
            b2_en = 1; b2_we = 1; b2_addr = 3'(j); b2_wdata = w72;
            tick();
            for (int l = 0; l < 8; l++) m2[8*j + l] = w72[9*l +: 9];
            chk("R6 x72 falls back to normal", b2_rdata, prev);
        end
        for (int j = 0; j < UN / 8; j++) begin
            b2_en = 1; b2_we = 0; b2_addr = 3'(j);
            tick();
            chk("R1 R2 x72 read", b2_rdata, pb2(j));
        end
        b2_en = 0; b2_we = 0;

        // R10: parity disabled never flags
        x9 = gu(6, 8); x9[8] = ~x9[8];
        a2_en = 1; a2_we = 1; a2_addr = 5'd3; a2_wdata = {x9, x9};
        tick();
        m2[6] = x9; m2[7] = x9;
        a2_we = 0;
        tick();
        chk("R10 bad bit8 kept", 72'(a2_rdata), 72'(pa2(3)));
        chk("R10 perr off when disabled", 72'(a2_perr), 72'h0);
        a2_en = 0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule